// File: doc/BRIEF.md
# Vending Controller with Expiry Check

This block sequences a single purchase at a product dispenser. A buyer asks for a transaction, picks one of four products by a 2-bit code, and the controller first looks at a per-product out-of-date flag. An out-of-date product is refused straight away: the controller raises its money-return strobe and closes the transaction. For any other product it collects credit from two coin sizes and one banknote size until the price is covered. It then fires the dispense strobe, pays back any surplus as change, and signals completion.

The outputs are Mealy type. Each strobe depends on the current state and on that cycle's inputs, so a cancel request or a stray credit pulse is answered in the same cycle it arrives. A credit pulse that arrives while the controller is not collecting money is handed straight back and is never added to the credit.

States, in order: `ST_START` (idle; `start_req` moves to `ST_SELECT`), `ST_SELECT` (captures `sel_code`, always moves to `ST_CHECK`), `ST_CHECK` (goes to `ST_FEEDBACK` with a refund if the product is out of date, otherwise to `ST_PAY`), `ST_PAY` (adds credit; `cancel_req` moves to `ST_FEEDBACK`; covered price moves to `ST_DISPENSE`), `ST_DISPENSE` (always moves to `ST_CHANGE`), `ST_CHANGE` (always moves to `ST_FEEDBACK`), `ST_FEEDBACK` (always moves to `ST_START`).

Top module: `vend_ctrl`

## Requirements
- R1: After `start_req`, the controller passes through select, check, payment, dispense, change and feedback on successive cycles, then returns to idle. It stays in payment for as long as the price is not covered.
- R2: If bit `sel_code` of `expired_flags` is 1 during the check cycle (two cycles after `start_req`), `refund_stb` is 1 with `refund_amt` 0 in that cycle, no dispense follows, and `done_pulse` comes in the next cycle.
- R3: In a payment cycle the credit grows by 1 for `coin_small`, 2 for `coin_large` and 10 for `note_in`. Pulses in the same cycle add up.
- R4: In the payment cycle where credit plus incoming value first reaches the price, nothing is strobed. In the next cycle `dispense_stb` is 1 for exactly one cycle, with `dispense_idx` equal to the selected code.
- R5: In the cycle after the dispense, `change_stb` is 1 with `change_amt` = credit − price if credit exceeds price. If credit equals price, `change_stb` stays 0.
- R6: `cancel_req` in a payment cycle gives `refund_stb` = 1 in that same cycle, with `refund_amt` equal to the stored credit plus that cycle's incoming value. No dispense follows, and `done_pulse` comes next.
- R7: A credit pulse in any state other than payment gives `refund_stb` = 1 in that cycle, with `refund_amt` equal to the pulse value. It is never added to the credit.
- R8: `done_pulse` lasts exactly one cycle, at the end of every transaction. Credit is cleared before the next transaction.
- R9: A synchronous active-high `rst` returns the controller to idle with the credit cleared. In the cycle after `rst`, no dispense, change or done strobe is raised.
- R10: Prices are 3, 5, 12 and 25 units for codes 0, 1, 2 and 3.
- R11: Refund strobes respond combinationally in the cycle of the input that causes them (Mealy outputs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Begin a transaction (idle only) |
| sel_code | input | 2 | Product code, captured in the select cycle |
| expired_flags | input | 4 | Out-of-date flag per product, bit n for code n |
| coin_small | input | 1 | Pulse: 1-unit coin |
| coin_large | input | 1 | Pulse: 2-unit coin |
| note_in | input | 1 | Pulse: 10-unit banknote |
| cancel_req | input | 1 | Abort during payment |
| dispense_stb | output | 1 | Release product |
| dispense_idx | output | 2 | Product being released |
| change_stb | output | 1 | Change amount valid |
| change_amt | output | 8 | Surplus credit returned |
| refund_stb | output | 1 | Money returned without sale |
| refund_amt | output | 8 | Amount returned |
| done_pulse | output | 1 | Transaction finished (feedback step) |

## Verification
The properties assume that `rst` is high from the first edge. They also assume that the prices and note value keep the credit inside 8 bits, which holds because credit only grows while it is below a price of at most 25. The bench changes inputs only at falling edges and samples the Mealy outputs one time unit later. It holds `sel_code` steady from the start request through the check cycle. It produces payment, cancel and stray pulses only as single-cycle events, so every strobe can be traced to exactly one cause.

// File: rtl/vend_pkg.sv
package vend_pkg;
    typedef enum logic [2:0] {
        ST_START,
        ST_SELECT,
        ST_CHECK,
        ST_PAY,
        ST_DISPENSE,
        ST_CHANGE,
        ST_FEEDBACK
    } vend_state_e;
endpackage

// File: rtl/vend_price.sv
module vend_price #(
    parameter int N_PROD = 4,
    parameter int CW = 8,
    parameter logic [N_PROD*CW-1:0] PRICES = '0,
    localparam int SW = $clog2(N_PROD)
) (
    input  logic [SW-1:0] sel,
    output logic [CW-1:0] price
);
    logic [CW-1:0] table_q [N_PROD];

    for (genvar i = 0; i < N_PROD; i++) begin : g_entry
        assign table_q[i] = PRICES[i*CW +: CW];
    end

    assign price = table_q[sel];
endmodule

// File: rtl/vend_credit.sv
module vend_credit #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          add_en,
    input  logic [CW-1:0] add_val,
    output logic [CW-1:0] credit
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            credit <= '0;
        else if (add_en)
            credit <= credit + add_val;
    end
endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
    import vend_pkg::*;
#(
    parameter int N_PROD = 4,
    parameter int CW = 8,
    localparam int SW = $clog2(N_PROD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic [SW-1:0]     sel_code,
    input  logic [N_PROD-1:0] expired_flags,
    input  logic              cancel_req,
    input  logic [CW-1:0]     pay_val,
    input  logic [CW-1:0]     credit,
    input  logic [CW-1:0]     price,
    output logic [SW-1:0]     sel_q,
    output logic              acc_en,
    output logic              acc_clr,
    output logic              dispense_stb,
    output logic              change_stb,
    output logic [CW-1:0]     change_amt,
    output logic              refund_stb,
    output logic [CW-1:0]     refund_amt,
    output logic              done_pulse
);
    vend_state_e state, state_nx;
    logic [CW:0] sum;

    assign sum = {1'b0, credit} + {1'b0, pay_val};

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_START;
            sel_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_SELECT)
                sel_q <= sel_code;
        end
    end

    always_comb begin
        state_nx     = state;
        acc_en       = 1'b0;
        acc_clr      = 1'b0;
        dispense_stb = 1'b0;
        change_stb   = 1'b0;
        change_amt   = '0;
        refund_stb   = 1'b0;
        refund_amt   = '0;
        done_pulse   = 1'b0;
        unique case (state)
            ST_START: begin
                if (start_req)
                    state_nx = ST_SELECT;
            end
            ST_SELECT: state_nx = ST_CHECK;
            ST_CHECK: begin
                if (expired_flags[sel_q]) begin
                    refund_stb = 1'b1;
                    state_nx   = ST_FEEDBACK;
                end else begin
                    state_nx = ST_PAY;
                end
            end
            ST_PAY: begin
                if (cancel_req) begin
                    refund_stb = 1'b1;
                    refund_amt = sum[CW-1:0];
                    state_nx   = ST_FEEDBACK;
                end else begin
                    acc_en = 1'b1;
                    if (sum >= {1'b0, price})
                        state_nx = ST_DISPENSE;
                end
            end
            ST_DISPENSE: begin
                dispense_stb = 1'b1;
                state_nx     = ST_CHANGE;
            end
            ST_CHANGE: begin
                if (credit > price) begin
                    change_stb = 1'b1;
                    change_amt = credit - price;
                end
                state_nx = ST_FEEDBACK;
            end
            ST_FEEDBACK: begin
                done_pulse = 1'b1;
                acc_clr    = 1'b1;
                state_nx   = ST_START;
            end
            default: state_nx = ST_START;
        endcase
        if (state != ST_PAY && pay_val != '0) begin
            refund_stb = 1'b1;
            refund_amt = refund_amt + pay_val;
        end
    end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
    parameter int N_PROD = 4,
    parameter int CW = 8,
    parameter logic [CW-1:0] VAL_SMALL = 8'd1,
    parameter logic [CW-1:0] VAL_LARGE = 8'd2,
    parameter logic [CW-1:0] VAL_NOTE  = 8'd10,
    parameter logic [N_PROD*CW-1:0] PRICES = {8'd25, 8'd12, 8'd5, 8'd3},
    localparam int SW = $clog2(N_PROD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic [SW-1:0]     sel_code,
    input  logic [N_PROD-1:0] expired_flags,
    input  logic              coin_small,
    input  logic              coin_large,
    input  logic              note_in,
    input  logic              cancel_req,
    output logic              dispense_stb,
    output logic [SW-1:0]     dispense_idx,
    output logic              change_stb,
    output logic [CW-1:0]     change_amt,
    output logic              refund_stb,
    output logic [CW-1:0]     refund_amt,
    output logic              done_pulse
);
    logic [CW-1:0] pay_val, credit, price;
    logic [SW-1:0] sel_q;
    logic          acc_en, acc_clr;

    assign pay_val = (coin_small ? VAL_SMALL : '0)
                   + (coin_large ? VAL_LARGE : '0)
                   + (note_in    ? VAL_NOTE  : '0);

    vend_price #(.N_PROD(N_PROD), .CW(CW), .PRICES(PRICES)) u_price (
        .sel   (sel_q),
        .price (price)
    );

    vend_credit #(.CW(CW)) u_credit (
        .clk     (clk),
        .rst     (rst),
        .clr     (acc_clr),
        .add_en  (acc_en),
        .add_val (pay_val),
        .credit  (credit)
    );

    vend_fsm #(.N_PROD(N_PROD), .CW(CW)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start_req     (start_req),
        .sel_code      (sel_code),
        .expired_flags (expired_flags),
        .cancel_req    (cancel_req),
        .pay_val       (pay_val),
        .credit        (credit),
        .price         (price),
        .sel_q         (sel_q),
        .acc_en        (acc_en),
        .acc_clr       (acc_clr),
        .dispense_stb  (dispense_stb),
        .change_stb    (change_stb),
        .change_amt    (change_amt),
        .refund_stb    (refund_stb),
        .refund_amt    (refund_amt),
        .done_pulse    (done_pulse)
    );

    assign dispense_idx = sel_q;
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          dispense_stb,
    input logic          change_stb,
    input logic [CW-1:0] change_amt,
    input logic          done_pulse
);
    // R9
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!dispense_stb && !change_stb && !done_pulse));

    // R4
    disp_single_chk: assert property (@(posedge clk) disable iff (rst)
        dispense_stb |=> (!dispense_stb && !done_pulse));

    // R5
    change_after_disp_chk: assert property (@(posedge clk) disable iff (rst)
        change_stb |-> $past(dispense_stb));

    // R5
    change_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        change_stb |-> (change_amt != '0));

    // R8
    done_after_disp_chk: assert property (@(posedge clk) disable iff (rst)
        dispense_stb |=> ##1 done_pulse);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);
endmodule

bind vend_ctrl vend_ctrl_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .dispense_stb (dispense_stb),
    .change_stb   (change_stb),
    .change_amt   (change_amt),
    .done_pulse   (done_pulse)
);

// File: tb/test_vend_ctrl.sv
module test_vend_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic [1:0] sel_code = '0;
    logic [3:0] expired_flags = '0;
    logic       coin_small = 1'b0, coin_large = 1'b0, note_in = 1'b0, cancel_req = 1'b0;
    logic       dispense_stb, change_stb, refund_stb, done_pulse;
    logic [1:0] dispense_idx;
    logic [7:0] change_amt, refund_amt;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vend_ctrl i_vend_ctrl (
        .clk(clk), .rst(rst), .start_req(start_req), .sel_code(sel_code),
        .expired_flags(expired_flags), .coin_small(coin_small), .coin_large(coin_large),
        .note_in(note_in), .cancel_req(cancel_req), .dispense_stb(dispense_stb),
        .dispense_idx(dispense_idx), .change_stb(change_stb), .change_amt(change_amt),
        .refund_stb(refund_stb), .refund_amt(refund_amt), .done_pulse(done_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        start_req = 0; coin_small = 0; coin_large = 0; note_in = 0; cancel_req = 0;
    endtask

    task automatic quiet(input string req);
        chk(req, {dispense_stb, change_stb, refund_stb, done_pulse}, 0);
    endtask

    // leaves the bench in the check cycle, outputs settled
    task automatic open_txn(input int p, input logic [3:0] flags);
        cyc(); start_req = 1; sel_code = 2'(p); expired_flags = flags; #1 quiet("R1 start");
        cyc(); #1 quiet("R1 select");
        cyc(); #1;
    endtask

    task automatic close_txn(input int idx, input int chg);
        cyc(); #1 chk("R4 dispense", dispense_stb, 1); chk("R4 idx", dispense_idx, idx);
        cyc(); #1 chk("R5 change strobe", change_stb, chg != 0);
        if (chg != 0) chk("R5 change amount", change_amt, chg);
        cyc(); #1 chk("R8 done", done_pulse, 1);
        cyc(); #1 chk("R8 done single", done_pulse, 0);
    endtask

    task automatic t_reset();
        cyc(); cyc(); #1 quiet("R9 reset outputs");
        cyc(); rst = 0; #1 quiet("R9 after reset");
    endtask

    task automatic t_exact();
        open_txn(1, 4'b0000); chk("R2 no refund", refund_stb, 0);
        cyc(); coin_large = 1; #1 quiet("R3 pay 2");
        cyc(); coin_large = 1; #1 quiet("R3 pay 4");
        cyc(); coin_small = 1; #1 quiet("R4 reach price quiet");
        close_txn(1, 0);
    endtask

    task automatic t_overpay();
        open_txn(0, 4'b0000);
        cyc(); note_in = 1; #1 quiet("R3 note");
        close_txn(0, 7);
    endtask

    task automatic t_price12();
        open_txn(2, 4'b0000);
        cyc(); note_in = 1; #1 quiet("R10 pay 10");
        cyc(); coin_small = 1; #1 quiet("R10 pay 11 below price");
        cyc(); coin_small = 1; #1 quiet("R10 pay 12");
        close_txn(2, 0);
    endtask

    task automatic t_expired();
        open_txn(2, 4'b0100);
        chk("R2 refund strobe", refund_stb, 1);
        chk("R2 refund amount", refund_amt, 0);
        chk("R2 no dispense", dispense_stb, 0);
        cyc(); #1 chk("R2 done next", done_pulse, 1); chk("R2 dispense", dispense_stb, 0);
        cyc(); #1 chk("R8 back idle", done_pulse, 0);
        expired_flags = '0;
    endtask

    task automatic t_cancel();
        open_txn(3, 4'b0000);
        cyc(); note_in = 1; #1 quiet("R6 pay 10");
        cyc(); coin_large = 1; #1 quiet("R6 pay 12");
        cyc(); cancel_req = 1; coin_small = 1; #1
        chk("R11 R6 refund same cycle", refund_stb, 1);
        chk("R6 refund amount", refund_amt, 13);
        cyc(); #1 chk("R6 done", done_pulse, 1); chk("R6 no dispense", dispense_stb, 0);
        chk("R6 refund single", refund_stb, 0);
        cyc(); #1 chk("R8 idle", done_pulse, 0);
    endtask

    task automatic t_stray();
        cyc(); note_in = 1; #1
        chk("R7 idle stray strobe", refund_stb, 1); chk("R7 idle stray amount", refund_amt, 10);
        open_txn(0, 4'b0000);
        cyc(); coin_small = 1; #1 quiet("R7 pay 1");
        cyc(); coin_small = 1; #1 quiet("R7 pay 2 not dispensed");
        cyc(); coin_small = 1; #1 quiet("R7 pay 3");
        cyc(); coin_large = 1; #1
        chk("R7 dispense with stray", dispense_stb, 1);
        chk("R7 stray in dispense", refund_stb, 1); chk("R7 stray amount", refund_amt, 2);
        cyc(); #1 chk("R7 no change from stray", change_stb, 0);
        cyc(); #1 chk("R8 done", done_pulse, 1);
        cyc(); #1;
    endtask

    task automatic t_mid_reset();
        open_txn(3, 4'b0000);
        cyc(); note_in = 1; #1 quiet("R9 pay 10");
        cyc(); rst = 1; #1;
        cyc(); rst = 0; #1 quiet("R9 after mid reset");
        open_txn(0, 4'b0000);
        cyc(); coin_small = 1; #1 quiet("R9 credit cleared 1");
        cyc(); coin_small = 1; #1 quiet("R9 credit cleared 2");
        cyc(); coin_small = 1; #1 quiet("R9 credit cleared 3");
        close_txn(0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_exact();
        t_overpay();
        t_price12();
        t_expired();
        t_cancel();
        t_stray();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule